// File: doc/BRIEF.md
# Cellular Automaton Scan Self-Test Engine

This block drives a set of parallel scan chains with pseudo-random stimulus and folds their responses into a signature. The stimulus comes from a hybrid linear cellular automaton (CA) that mixes rule-90 and rule-150 cells and treats the cells beyond both ends as zero. There is one CA cell for each chain, so every chain gets its own generator stage, and neighbouring chains receive bits that are only weakly correlated. The compactor is a multiple-input signature register (MISR), also with one cell per chain.

A controller runs the test after a start pulse. It loads the CA seed and clears the MISR. For each pattern it holds scan enable high for one chain length of shift cycles and then drops it for one capture cycle. After the last pattern's capture, it runs one more chain length of shift cycles so that the final responses are also compacted. It then raises a single done flag. While done is high, the signature stays frozen and is presented at the outputs. A pass flag reports whether the signature matches a value supplied from outside.

Top module: `cabist_engine`

## Requirements
- R1: While reset is asserted and right after it, scan_en, done and pass are 0, chain_si equals CA_SEED, and signature is 0. A reset during a run aborts the run.
- R2: The CA next state of cell i is the XOR of cells i-1 and i+1, with out-of-range neighbours read as 0. Cell i also adds its own value when RULE150[i] is 1. With 7 cells and RULE150 = 7'b0100001, the CA visits 127 distinct non-zero states and returns to the seed on step 127.
- R3: Bit i of chain_si is the serial input of chain i. The CA steps once per cycle in which scan_en is high. A run has CHAIN_LEN*PATTERNS + CHAIN_LEN such cycles.
- R4: A start pulse in idle or done state begins a run. Each of the PATTERNS patterns is CHAIN_LEN cycles with scan_en high, followed by one capture cycle with scan_en low.
- R5: During a capture cycle, neither the CA nor the MISR changes state.
- R6: After the last capture, CHAIN_LEN unload shift cycles follow, and then done rises. It rises PATTERNS*(CHAIN_LEN+1)+CHAIN_LEN clock edges after the edge that samples start. Done then stays high until the next start.
- R7: On every shift cycle the signature becomes (sig<<1) XOR chain_so. When the old top bit sig[N-1] is 1, it is also XORed with MISR_POLY. The signature is frozen while done is high.
- R8: Pass is 1 only while done is high and signature equals expected_sig. It follows changes of expected_sig within the same cycle.
- R9: A start pulse during a run is ignored. The run's length and its signature do not change.
- R10: A new start after done re-seeds the CA and clears the MISR. The signature then depends only on the chain contents and the responses of that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a run when the engine is idle or done |
| expected_sig | input | N_CHAINS | Signature that the run is compared against |
| chain_so | input | N_CHAINS | Serial outputs of the scan chains, one bit per chain |
| chain_si | output | N_CHAINS | Serial inputs of the scan chains (CA state) |
| scan_en | output | 1 | High on shift cycles, low on capture and when idle |
| done | output | 1 | Test-complete flag |
| pass | output | 1 | Signature matches expected_sig while done |
| signature | output | N_CHAINS | MISR contents |

## Verification
The bench builds the engine with 7 chains of 8 flip-flops and 16 patterns. With these values a single run makes 136 CA steps. That covers the full 127-state cycle of the built-in rule vector, so the wrap back to the seed is observed inside every run. The short chains keep a run at 152 cycles. This leaves room for several back-to-back runs in which the chain contents carried over differ each time, plus an aborted run and a start pulse that arrives mid-run. The chains are modelled as shift registers that apply a fixed logic function on capture. An independent software model of the CA, the MISR and the chains predicts every signature.

// File: rtl/cabist_pkg.sv
package cabist_pkg;

    // Controller phases of one self-test run
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SHIFT   = 3'd1,
        ST_CAPTURE = 3'd2,
        ST_UNLOAD  = 3'd3,
        ST_DONE    = 3'd4
    } bist_state_e;

endpackage

// File: rtl/cabist_ca_gen.sv
module cabist_ca_gen #(
    parameter int               WIDTH   = 7,
    parameter logic [WIDTH-1:0] RULE150 = 7'b0100001,
    parameter logic [WIDTH-1:0] SEED    = 7'b0000001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [WIDTH-1:0] state
);

    logic [WIDTH-1:0] state_d, state_q;
    logic [WIDTH-1:0] evolve;
    logic [WIDTH+1:0] padded;

    // Null boundary: zero cells on both sides of the array
    assign padded = {1'b0, state_q, 1'b0};

    for (genvar c = 0; c < WIDTH; c++) begin : g_cell
        // padded[c] is the neighbour below, padded[c+2] the neighbour above
        assign evolve[c] = padded[c] ^ padded[c+2] ^ (RULE150[c] & state_q[c]);
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = SEED;
        end else if (step) begin
            state_d = evolve;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    AST_CA_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0); // R2

    AST_CA_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> state_q != $past(state_q)); // R3

endmodule

// File: rtl/cabist_misr.sv
module cabist_misr #(
    parameter int               WIDTH = 7,
    parameter logic [WIDTH-1:0] POLY  = 7'b0000011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] sig
);

    logic [WIDTH-1:0] sig_d, sig_q;
    logic [WIDTH-1:0] folded;
    logic             msb;

    assign msb = sig_q[WIDTH-1];

    // Cell 0 takes the feedback directly, higher cells take their lower neighbour
    assign folded[0] = (msb & POLY[0]) ^ din[0];
    for (genvar c = 1; c < WIDTH; c++) begin : g_cell
        assign folded[c] = sig_q[c-1] ^ (msb & POLY[c]) ^ din[c];
    end

    always_comb begin
        sig_d = sig_q;
        if (clear) begin
            sig_d = '0;
        end else if (step) begin
            sig_d = folded;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else begin
            sig_q <= sig_d;
        end
    end

    assign sig = sig_q;

    AST_MISR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> sig_q == '0); // R10

endmodule

// File: rtl/cabist_ctrl.sv
module cabist_ctrl
    import cabist_pkg::*;
#(
    parameter int CHAIN_LEN = 64,
    parameter int PATTERNS  = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic seed_load,
    output logic scan_en,
    output logic done
);

    localparam int LEN_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam int PAT_W = (PATTERNS > 1) ? $clog2(PATTERNS) : 1;
    localparam logic [LEN_W-1:0] LAST_BIT = LEN_W'(CHAIN_LEN - 1);
    localparam logic [PAT_W-1:0] LAST_PAT = PAT_W'(PATTERNS - 1);

    typedef struct packed {
        bist_state_e      state;
        logic [LEN_W-1:0] bit_cnt;
        logic [PAT_W-1:0] pat_cnt;
    } ctrl_reg_t;

    ctrl_reg_t r_d, r_q;
    logic      accept;

    assign accept = start && (r_q.state == ST_IDLE || r_q.state == ST_DONE);

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    r_d.state   = ST_SHIFT;
                    r_d.bit_cnt = '0;
                    r_d.pat_cnt = '0;
                end
            end
            ST_SHIFT: begin
                if (r_q.bit_cnt == LAST_BIT) begin
                    r_d.bit_cnt = '0;
                    r_d.state   = ST_CAPTURE;
                end else begin
                    r_d.bit_cnt = r_q.bit_cnt + LEN_W'(1);
                end
            end
            ST_CAPTURE: begin
                if (r_q.pat_cnt == LAST_PAT) begin
                    r_d.state = ST_UNLOAD;
                end else begin
                    r_d.pat_cnt = r_q.pat_cnt + PAT_W'(1);
                    r_d.state   = ST_SHIFT;
                end
            end
            ST_UNLOAD: begin
                if (r_q.bit_cnt == LAST_BIT) begin
                    r_d.bit_cnt = '0;
                    r_d.state   = ST_DONE;
                end else begin
                    r_d.bit_cnt = r_q.bit_cnt + LEN_W'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, bit_cnt: '0, pat_cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign seed_load = accept;
    assign scan_en   = (r_q.state == ST_SHIFT) || (r_q.state == ST_UNLOAD);
    assign done      = (r_q.state == ST_DONE);

    AST_CAPTURE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SHIFT && r_q.bit_cnt == LAST_BIT) |=> !scan_en); // R4

    AST_DONE_AFTER_UNLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(r_q.state) == ST_UNLOAD); // R6

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R6

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SHIFT && start && r_q.bit_cnt != LAST_BIT)
        |=> (r_q.state == ST_SHIFT && r_q.bit_cnt == $past(r_q.bit_cnt) + LEN_W'(1))); // R9

endmodule

// File: rtl/cabist_engine.sv
module cabist_engine #(
    parameter int                  N_CHAINS  = 7,
    parameter int                  CHAIN_LEN = 64,
    parameter int                  PATTERNS  = 1024,
    parameter logic [N_CHAINS-1:0] RULE150   = 7'b0100001,
    parameter logic [N_CHAINS-1:0] MISR_POLY = 7'b0000011,
    parameter logic [N_CHAINS-1:0] CA_SEED   = 7'b0000001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [N_CHAINS-1:0] expected_sig,
    input  logic [N_CHAINS-1:0] chain_so,
    output logic [N_CHAINS-1:0] chain_si,
    output logic                scan_en,
    output logic                done,
    output logic                pass,
    output logic [N_CHAINS-1:0] signature
);

    logic seed_load;

    cabist_ctrl #(
        .CHAIN_LEN (CHAIN_LEN),
        .PATTERNS  (PATTERNS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .seed_load (seed_load),
        .scan_en   (scan_en),
        .done      (done)
    );

    cabist_ca_gen #(
        .WIDTH   (N_CHAINS),
        .RULE150 (RULE150),
        .SEED    (CA_SEED)
    ) u_ca (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seed_load),
        .step  (scan_en),
        .state (chain_si)
    );

    cabist_misr #(
        .WIDTH (N_CHAINS),
        .POLY  (MISR_POLY)
    ) u_misr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (seed_load),
        .step  (scan_en),
        .din   (chain_so),
        .sig   (signature)
    );

    assign pass = done && (signature == expected_sig);

    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !seed_load) |=> ($stable(chain_si) && $stable(signature))); // R5

    AST_SIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(signature)); // R7

    AST_PASS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done) && done && $stable(expected_sig)) |-> pass == $past(pass)); // R8

    AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> !pass); // R8

endmodule

// File: tb/cabist_engine_bench.sv
module cabist_engine_bench;

    localparam int N          = 7;
    localparam int L          = 8;
    localparam int P          = 16;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYC    = P * (L + 1) + L;
    localparam int SHIFTS     = L * P + L;
    localparam int PERIOD     = (1 << N) - 1;
    localparam int WATCHDOG   = 20000;
    localparam logic [N-1:0] RULE = 7'b0100001;
    localparam logic [N-1:0] POLY = 7'b0000011;
    localparam logic [N-1:0] SEED = 7'b0000001;

    typedef struct packed {
        logic [N-1:0] mask;
        logic         exp_pass;
        logic         poke;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{mask: 7'h00, exp_pass: 1'b1, poke: 1'b0},
        '{mask: 7'h01, exp_pass: 1'b0, poke: 1'b0},
        '{mask: 7'h00, exp_pass: 1'b1, poke: 1'b1},
        '{mask: 7'h40, exp_pass: 1'b0, poke: 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] expected_sig = '0;
    logic [N-1:0] chain_so;
    logic [N-1:0] chain_si;
    logic         scan_en, done, pass;
    logic [N-1:0] signature;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cabist_engine #(
        .N_CHAINS  (N),
        .CHAIN_LEN (L),
        .PATTERNS  (P),
        .RULE150   (RULE),
        .MISR_POLY (POLY),
        .CA_SEED   (SEED)
    ) u_cabist_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .expected_sig (expected_sig),
        .chain_so     (chain_so),
        .chain_si     (chain_si),
        .scan_en      (scan_en),
        .done         (done),
        .pass         (pass),
        .signature    (signature)
    );

    // Scan chain model: shift on scan_en, apply a fixed logic function on its falling edge
    logic [L-1:0] chain_q [N];
    logic         sen_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) chain_q[i] <= '0;
            sen_prev <= 1'b0;
        end else begin
            sen_prev <= scan_en;
            for (int i = 0; i < N; i++) begin
                if (scan_en) chain_q[i] <= {chain_q[i][L-2:0], chain_si[i]};
                else if (sen_prev) chain_q[i] <= ~chain_q[i] ^ chain_q[(i + 1) % N];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) chain_so[i] = chain_q[i][L-1];
    end

    // Software reference model
    logic [L-1:0] m_chain [N];

    function automatic logic [N-1:0] ref_ca(input logic [N-1:0] c);
        logic [N+1:0] e;
        logic [N-1:0] r;
        e = {1'b0, c, 1'b0};
        for (int i = 0; i < N; i++) r[i] = e[i] ^ e[i+2] ^ (RULE[i] & c[i]);
        return r;
    endfunction

    function automatic logic [N-1:0] ref_misr(input logic [N-1:0] m, input logic [N-1:0] d);
        return {m[N-2:0], 1'b0} ^ (m[N-1] ? POLY : '0) ^ d;
    endfunction

    task automatic model_capture();
        logic [L-1:0] tmp [N];
        for (int i = 0; i < N; i++) tmp[i] = m_chain[i];
        for (int i = 0; i < N; i++) m_chain[i] = ~tmp[i] ^ tmp[(i + 1) % N];
    endtask

    task automatic model_shift(inout logic [N-1:0] ca, inout logic [N-1:0] sig);
        logic [N-1:0] so;
        for (int i = 0; i < N; i++) so[i] = m_chain[i][L-1];
        sig = ref_misr(sig, so);
        for (int i = 0; i < N; i++) m_chain[i] = {m_chain[i][L-2:0], ca[i]};
        ca = ref_ca(ca);
    endtask

    task automatic model_run(output logic [N-1:0] sig);
        logic [N-1:0] ca;
        ca  = SEED;
        sig = '0;
        for (int p = 0; p < P; p++) begin
            for (int b = 0; b < L; b++) model_shift(ca, sig);
            model_capture();
        end
        for (int b = 0; b < L; b++) model_shift(ca, sig);
        model_capture();
    endtask

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input logic [N-1:0] mask, input logic exp_pass,
                           input logic poke, input string sig_req);
        logic [N-1:0]        exp_sig, first_v, low_v;
        logic [PERIOD:0]     seen;
        logic                dup, wrap, zero_hit, hold_bad, prev_low;
        int                  cyc, lows, shifts;
        model_run(exp_sig);
        seen = '0; dup = 1'b0; wrap = 1'b0; zero_hit = 1'b0; hold_bad = 1'b0;
        prev_low = 1'b0; first_v = '0; low_v = '0; lows = 0; shifts = 0;
        @(negedge clk);
        expected_sig = exp_sig ^ mask;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < RUN_CYC + 50) begin
            if (scan_en) begin
                if (shifts < PERIOD) begin
                    if (seen[chain_si]) dup = 1'b1;
                    seen[chain_si] = 1'b1;
                    if (chain_si == '0) zero_hit = 1'b1;
                end
                if (shifts == 0) first_v = chain_si;
                if (shifts == PERIOD) wrap = (chain_si == first_v);
                if (prev_low && chain_si != low_v) hold_bad = 1'b1;
                prev_low = 1'b0;
                shifts++;
            end else begin
                lows++;
                low_v = chain_si;
                prev_low = 1'b1;
            end
            @(negedge clk);
            cyc++;
            start = (poke && cyc == 40);
        end
        start = 1'b0;
        check(cyc == RUN_CYC, poke ? "R9" : "R6", "cycles from start to done", cyc, RUN_CYC);
        check(lows == P, "R4", "capture cycles per run", lows, P);
        check(shifts == SHIFTS, "R3", "shift cycles per run", shifts, SHIFTS);
        check(!dup && wrap && !zero_hit, "R2", "CA full-period walk", {dup, wrap, zero_hit}, 3'b010);
        check(!hold_bad, "R5", "CA held across capture", hold_bad, 0);
        check(signature == exp_sig, sig_req, "signature", signature, exp_sig);
        check(pass == exp_pass, "R8", "pass flag", pass, exp_pass);
        repeat (3) @(negedge clk);
        check(done && signature == exp_sig, "R7", "done and signature held", {done, signature}, {1'b1, exp_sig});
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++;
        $display("FAIL R6 watchdog: actual 0x0 expected 0x1 (run never completed)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_chain[i] = '0;
        repeat (3) @(negedge clk);
        check(!scan_en && !done && !pass, "R1", "control outputs in reset", {scan_en, done, pass}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scan_en && !done && !pass, "R1", "control outputs after reset", {scan_en, done, pass}, 0);
        check(chain_si == SEED && signature == '0, "R1", "CA and MISR after reset", {chain_si, signature}, {SEED, 7'h00});

        // Vector table: first entry is a fresh run, later ones restart from done
        for (int v = 0; v < 4; v++) begin
            run_one(VECS[v].mask, VECS[v].exp_pass, VECS[v].poke, (v == 0) ? "R7" : "R10");
        end

        // R8: pass follows expected_sig while done
        @(negedge clk);
        expected_sig = signature;
        #1;
        check(pass == 1'b1, "R8", "pass after matching expected_sig", pass, 1);
        expected_sig = ~signature;
        #1;
        check(pass == 1'b0, "R8", "pass after mismatching expected_sig", pass, 0);

        // R1: reset in the middle of a run aborts it
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        #1;
        for (int i = 0; i < N; i++) m_chain[i] = '0;
        @(negedge clk);
        check(!scan_en && !done && chain_si == SEED && signature == '0, "R1",
              "mid-run reset state", {scan_en, done, chain_si, signature}, {2'b00, SEED, 7'h00});
        rst_n = 1'b1;
        @(negedge clk);

        // R10: a clean run after the aborted one
        run_one('0, 1'b1, 1'b0, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule